// File: doc/BRIEF.md
# Descriptor-Driven Memory Copy Channel

This block is one memory-to-memory copy channel. Software does not program a copy directly. It places a small descriptor of four 32-bit words in memory and writes the descriptor's byte address into the channel. It then sets the run bit. The channel reads the descriptor, then copies 32-bit words from a source address to a destination address. Each address either advances by four bytes per word or stays fixed, as the descriptor's option bits select.

When the last word has been written, the channel clears its run bit. It then emits a one-cycle completion pulse, and also an interrupt pulse if the descriptor asked for one.

The register side is a plain write strobe with a combinational read. The memory side is a single-word master. It holds a request until the memory returns `mem_ready` in the same cycle. Read data is taken in that cycle.

Top module: `dma_cb_engine`

## Requirements
- R1: After reset the run bit reads 0, the descriptor-address register reads 0, and `mem_req`, `done` and `irq` are low.
- R2: The register at byte offset 0x4 holds the descriptor address and reads back what was written. A write to it while the channel runs is ignored.
- R3: A write to offset 0x0 with bit 0 set starts an idle channel. Bit 0 of offset 0x0 reads 1 from the next cycle until completion. Such a write while running, or with bit 0 clear, has no effect.
- R4: Before any data access the channel reads four descriptor words, at addresses A, A+4, A+8 and A+12 in that order. The words are: option word, source address, destination address, length in bytes.
- R5: The copy moves ceil(length/4) words, in order. For each word it makes one read from the source, then one write of that data to the destination.
- R6: Option bit 8 makes the source advance by 4 after each word, and option bit 4 does the same for the destination. When the bit is clear, that address stays the same for every word.
- R7: `done` is high for exactly one cycle after the last access, and in that cycle the run bit already reads 0.
- R8: `irq` pulses together with `done` if bit 0 of the option word was set, and stays low otherwise.
- R9: A length of 0 completes right after the four descriptor reads, with no data access.
- R10: `mem_req` is low while idle. A request that is not yet accepted keeps its address and direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | REG_AW | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid with `mem_ready` |
| mem_ready | input | 1 | Access accepted this cycle |
| done | output | 1 | Completion pulse |
| irq | output | 1 | Completion interrupt pulse |

## Verification
Two events can fall in the same clock edge.

The first pair is the acceptance of the last memory access and the return to idle. Here the run bit must drop and the completion and interrupt pulses must appear together, one cycle later. The bench provokes this with a sweep over memory latencies 0 to 2, over all option-bit combinations, and over lengths of 0, 1, 2 and 8 words. It judges the result from the logged access sequence and the final destination contents.

The second pair is a software register write landing while the channel is running. The bench checks that a descriptor-address rewrite and a repeated start are both ignored. It does this by reading the register back and counting accesses.

// File: rtl/dma_cb_pkg.sv
package dma_cb_pkg;
  localparam int DMA_AW = 32;
  localparam int DMA_DW = 32;
  localparam int DESC_WORDS = 4;
  localparam int DESC_IW = $clog2(DESC_WORDS);
  localparam int OPT_IRQ_BIT = 0;
  localparam int OPT_DSTEP_BIT = 4;
  localparam int OPT_SSTEP_BIT = 8;
  localparam int OFS_RUN = 0;
  localparam int OFS_DESC = 4;

  typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_READ, ST_WRITE} chan_state_e;

  function automatic logic [DMA_AW-1:0] step_addr(input logic [DMA_AW-1:0] a, input logic adv);
    return adv ? a + DMA_AW'(DMA_DW / 8) : a;
  endfunction

  function automatic logic [DMA_AW-1:0] word_count(input logic [DMA_DW-1:0] nbytes);
    return DMA_AW'(nbytes >> 2) + DMA_AW'(|nbytes[1:0]);
  endfunction

  function automatic logic [DMA_AW-1:0] desc_addr(input logic [DMA_AW-1:0] base,
                                                   input logic [DESC_IW-1:0] idx);
    return base + DMA_AW'({idx, 2'b00});
  endfunction
endpackage

// File: rtl/dma_cb_regs.sv
module dma_cb_regs
  import dma_cb_pkg::*;
#(
  parameter int REG_AW = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [DMA_DW-1:0] reg_wdata,
  input  logic              busy,
  output logic [DMA_DW-1:0] reg_rdata,
  output logic [DMA_AW-1:0] desc_base,
  output logic              start
);
  logic hit_run, hit_desc;

  assign hit_run  = reg_addr == REG_AW'(OFS_RUN);
  assign hit_desc = reg_addr == REG_AW'(OFS_DESC);
  assign start    = reg_wr && hit_run && reg_wdata[0] && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) desc_base <= '0;
    else if (reg_wr && hit_desc && !busy) desc_base <= reg_wdata;
  end

  always_comb begin
    reg_rdata = '0;
    if (hit_run) reg_rdata = {{(DMA_DW-1){1'b0}}, busy};
    else if (hit_desc) reg_rdata = desc_base;
  end

  AST_DESC_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(desc_base)); // R2
endmodule

// File: rtl/dma_cb_seq.sv
module dma_cb_seq
  import dma_cb_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               mem_ready,
  input  logic               len_zero,
  input  logic               last_word,
  output chan_state_e        state,
  output logic [DESC_IW-1:0] fetch_idx,
  output logic               busy,
  output logic               done
);
  logic fetch_last;

  assign busy       = state != ST_IDLE;
  assign fetch_last = fetch_idx == DESC_IW'(DESC_WORDS - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      fetch_idx <= '0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: if (start) begin
          state     <= ST_FETCH;
          fetch_idx <= '0;
        end
        ST_FETCH: if (mem_ready) begin
          if (fetch_last) begin
            if (len_zero) begin
              state <= ST_IDLE;
              done  <= 1'b1;
            end else begin
              state <= ST_READ;
            end
          end else begin
            fetch_idx <= fetch_idx + 1'b1;
          end
        end
        ST_READ: if (mem_ready) state <= ST_WRITE;
        ST_WRITE: if (mem_ready) begin
          if (last_word) begin
            state <= ST_IDLE;
            done  <= 1'b1;
          end else begin
            state <= ST_READ;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7
  AST_START_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy); // R3
endmodule

// File: rtl/dma_cb_path.sv
module dma_cb_path
  import dma_cb_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  chan_state_e        state,
  input  logic [DESC_IW-1:0] fetch_idx,
  input  logic [DMA_AW-1:0]  desc_base,
  input  logic [DMA_DW-1:0]  mem_rdata,
  input  logic               mem_ready,
  output logic               mem_req,
  output logic               mem_we,
  output logic [DMA_AW-1:0]  mem_addr,
  output logic [DMA_DW-1:0]  mem_wdata,
  output logic               len_zero,
  output logic               last_word,
  output logic               irq_en
);
  logic [DMA_AW-1:0] src_q, dst_q, left_q;
  logic [DMA_DW-1:0] data_q;
  logic              sstep_q, dstep_q;
  logic              acc_fetch, acc_read, acc_write;

  assign mem_req   = state != ST_IDLE;
  assign mem_we    = state == ST_WRITE;
  assign mem_wdata = data_q;
  assign acc_fetch = state == ST_FETCH && mem_ready;
  assign acc_read  = state == ST_READ && mem_ready;
  assign acc_write = state == ST_WRITE && mem_ready;
  assign len_zero  = word_count(mem_rdata) == '0;
  assign last_word = left_q == DMA_AW'(1);

  always_comb begin
    case (state)
      ST_FETCH: mem_addr = desc_addr(desc_base, fetch_idx);
      ST_READ:  mem_addr = src_q;
      ST_WRITE: mem_addr = dst_q;
      default:  mem_addr = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q   <= '0;
      dst_q   <= '0;
      left_q  <= '0;
      data_q  <= '0;
      sstep_q <= 1'b0;
      dstep_q <= 1'b0;
      irq_en  <= 1'b0;
    end else begin
      if (acc_fetch) begin
        case (fetch_idx)
          2'd0: begin
            irq_en  <= mem_rdata[OPT_IRQ_BIT];
            dstep_q <= mem_rdata[OPT_DSTEP_BIT];
            sstep_q <= mem_rdata[OPT_SSTEP_BIT];
          end
          2'd1: src_q <= mem_rdata;
          2'd2: dst_q <= mem_rdata;
          default: left_q <= word_count(mem_rdata);
        endcase
      end
      if (acc_read) data_q <= mem_rdata;
      if (acc_write) begin
        src_q  <= step_addr(src_q, sstep_q);
        dst_q  <= step_addr(dst_q, dstep_q);
        left_q <= left_q - 1'b1;
      end
    end
  end

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we)); // R10
endmodule

// File: rtl/dma_cb_engine.sv
module dma_cb_engine
  import dma_cb_pkg::*;
#(
  parameter int REG_AW = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [DMA_DW-1:0] reg_wdata,
  output logic [DMA_DW-1:0] reg_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [DMA_AW-1:0] mem_addr,
  output logic [DMA_DW-1:0] mem_wdata,
  input  logic [DMA_DW-1:0] mem_rdata,
  input  logic              mem_ready,
  output logic              done,
  output logic              irq
);
  chan_state_e        state;
  logic [DESC_IW-1:0] fetch_idx;
  logic [DMA_AW-1:0]  desc_base;
  logic               busy, start, len_zero, last_word, irq_en;

  dma_cb_regs #(.REG_AW(REG_AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .busy(busy), .reg_rdata(reg_rdata),
    .desc_base(desc_base), .start(start)
  );

  dma_cb_seq u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .mem_ready(mem_ready),
    .len_zero(len_zero), .last_word(last_word), .state(state),
    .fetch_idx(fetch_idx), .busy(busy), .done(done)
  );

  dma_cb_path u_path (
    .clk(clk), .rst_n(rst_n), .state(state), .fetch_idx(fetch_idx),
    .desc_base(desc_base), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .len_zero(len_zero), .last_word(last_word),
    .irq_en(irq_en)
  );

  assign irq = done && irq_en;

  AST_IRQ_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> done); // R8
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && !mem_req); // R7
endmodule

// File: tb/dma_cb_engine_test.sv
module dma_cb_engine_test;
  localparam int CLK_PERIOD = 10;
  localparam int MEM_WORDS = 256;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        mem_req, mem_we, mem_ready = 1'b0, done, irq;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;

  logic [31:0] mem [MEM_WORDS];
  logic [31:0] log_addr [64];
  logic [31:0] log_data [64];
  logic        log_we [64];
  int          n_log = 0;
  int          lat = 0, wait_cnt = 0;
  int          tests = 0, fails = 0;

  dma_cb_engine uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ready(mem_ready), .done(done), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    if (mem_req) begin
      if (wait_cnt >= lat) begin
        mem_ready = 1'b1;
        mem_rdata = mem[mem_addr[9:2]];
        wait_cnt  = 0;
      end else begin
        mem_ready = 1'b0;
        wait_cnt++;
      end
    end else begin
      mem_ready = 1'b0;
      wait_cnt  = 0;
    end
  end

  always @(posedge clk) begin
    if (mem_req && mem_ready) begin
      if (n_log < 64) begin
        log_addr[n_log] = mem_addr;
        log_we[n_log]   = mem_we;
        log_data[n_log] = mem_we ? mem_wdata : mem_rdata;
      end
      n_log++;
      if (mem_we) mem[mem_addr[9:2]] = mem_wdata;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic reg_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  function automatic logic [31:0] pat(input int i, input int seed);
    return 32'hA500_0000 ^ (i * 32'h0001_0203) ^ (seed * 32'h0110_0000);
  endfunction

  task automatic run_xfer(input logic [31:0] cb, input logic [31:0] src, input logic [31:0] dst,
                          input logic [31:0] len, input logic sst, input logic dst_st,
                          input logic ien, input int seed, input bit poke);
    logic [31:0] opt, expd [8], old_cb;
    int words, cyc, k;
    bit seen;
    opt = {23'd0, sst, 3'd0, dst_st, 3'd0, ien};
    words = (len + 3) / 4;
    for (int i = 0; i < 8; i++) begin
      mem[src[9:2] + i] = pat(i, seed);
      mem[dst[9:2] + i] = 32'h0;
      expd[i] = 32'h0;
    end
    mem[cb[9:2]] = opt; mem[cb[9:2] + 1] = src;
    mem[cb[9:2] + 2] = dst; mem[cb[9:2] + 3] = len;
    for (int i = 0; i < words; i++) expd[dst_st ? i : 0] = pat(sst ? i : 0, seed);
    reg_write(4'h4, cb);
    old_cb = cb;
    n_log = 0;
    reg_write(4'h0, 32'h1);
    reg_addr = 4'h0;
    #1 chk(reg_rdata[0] == 1'b1, "R3 run bit set", reg_rdata, 32'h1);
    if (poke) begin
      reg_write(4'h4, 32'h3C0);
      reg_write(4'h0, 32'h1);
    end
    seen = 0;
    for (cyc = 0; cyc < 400; cyc++) begin
      @(negedge clk);
      if (done) begin seen = 1; break; end
    end
    chk(seen, "R7 done seen", {31'd0, seen}, 32'h1);
    if (seen) begin
      reg_addr = 4'h0;
      #1 chk(reg_rdata[0] == 1'b0, "R7 run bit clear at done", reg_rdata, 32'h0);
      chk(irq == ien, "R8 irq follows option bit 0", {31'd0, irq}, {31'd0, ien});
      @(negedge clk);
      chk(!done && !irq, "R7 done one cycle", {30'd0, done, irq}, 32'h0);
    end
    chk(n_log == 4 + 2 * words, words == 0 ? "R9 access count" : "R5 access count", n_log, 4 + 2 * words);
    for (int i = 0; i < 4 && i < n_log; i++)
      chk(!log_we[i] && log_addr[i] == cb + 4 * i, "R4 descriptor fetch", log_addr[i], cb + 4 * i);
    for (k = 0; k < words && 5 + 2 * k < n_log && 5 + 2 * k < 64; k++) begin
      chk(!log_we[4 + 2 * k] && log_addr[4 + 2 * k] == src + (sst ? 4 * k : 0),
          "R6 source address", log_addr[4 + 2 * k], src + (sst ? 4 * k : 0));
      chk(log_we[5 + 2 * k] && log_addr[5 + 2 * k] == dst + (dst_st ? 4 * k : 0),
          "R6 destination address", log_addr[5 + 2 * k], dst + (dst_st ? 4 * k : 0));
      chk(log_data[5 + 2 * k] == pat(sst ? k : 0, seed), "R5 written data",
          log_data[5 + 2 * k], pat(sst ? k : 0, seed));
    end
    for (int i = 0; i < 8; i++)
      chk(mem[dst[9:2] + i] == expd[i], "R5 destination contents", mem[dst[9:2] + i], expd[i]);
    if (poke) begin
      reg_addr = 4'h4;
      #1 chk(reg_rdata == old_cb, "R2 write while running ignored", reg_rdata, old_cb);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int seed;
    logic [31:0] lens [4];
    lens[0] = 0; lens[1] = 4; lens[2] = 6; lens[3] = 32;
    for (int i = 0; i < MEM_WORDS; i++) mem[i] = 32'h0;
    repeat (3) @(negedge clk);
    reg_addr = 4'h0;
    #1 chk(reg_rdata == 32'h0, "R1 run bit after reset", reg_rdata, 32'h0);
    chk(!mem_req && !done && !irq, "R1 outputs idle", {29'd0, mem_req, done, irq}, 32'h0);
    reg_addr = 4'h4;
    #1 chk(reg_rdata == 32'h0, "R1 descriptor address after reset", reg_rdata, 32'h0);
    rst_n = 1'b1;
    reg_write(4'h4, 32'h0000_0ABC);
    reg_addr = 4'h4;
    #1 chk(reg_rdata == 32'h0000_0ABC, "R2 readback", reg_rdata, 32'h0000_0ABC);
    reg_write(4'h0, 32'hFFFF_FFFE);
    begin
      bit any_req;
      any_req = 0;
      for (int c = 0; c < 6; c++) begin
        @(negedge clk);
        if (mem_req) any_req = 1;
      end
      reg_addr = 4'h0;
      #1 chk(!any_req && reg_rdata == 32'h0, "R3 bit 0 clear does not start",
             {31'd0, any_req}, 32'h0);
      chk(!any_req, "R10 no request while idle", {31'd0, any_req}, 32'h0);
    end
    seed = 0;
    for (int l = 0; l < 3; l++) begin
      lat = l;
      for (int opt = 0; opt < 8; opt++) begin
        for (int li = 0; li < 4; li++) begin
          seed++;
          run_xfer(32'h300 + 16 * l, 32'h000, 32'h100, lens[li],
                   opt[2], opt[1], opt[0], seed, 1'b0);
        end
      end
    end
    lat = 2;
    run_xfer(32'h340, 32'h040, 32'h180, 32'd32, 1'b1, 1'b1, 1'b1, 99, 1'b1);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule